// File: doc/BRIEF.md
# Receive Word Saturator with Latched Clip Flag

This block sits at the end of a receive path, where the decimated result is still wider than the 16-bit word handed to the downstream processor. Each valid result is clamped to the limits of the output format that is currently selected, then registered and presented with a valid pulse. The format is either a full-range 16-bit word with a single sign bit, or a narrower word with two sign bits whose top two bits always agree.

Each time a result has to be clamped, a clip flag is raised. The flag stays high until software writes a zero into the clear position of the control register that owns it. Writes to other addresses, or writes that leave that bit at one, leave the flag alone. If a clamp and a clearing write land in the same cycle, the flag stays set, so no overload can be lost.

Top module: `rx_sat_clip`

## Requirements
- R1: With `fmt_one_sign` = 1, a sample above 32767 is output as 0x7FFF, a sample below -32768 is output as 0x8000, and 0x7FFF / 0x0000 / 0x8000 stand for positive full scale, mid-scale and negative full scale.
- R2: With `fmt_one_sign` = 0, a sample above 16383 is output as 0x3FFF, a sample below -16384 is output as 0xC000, and 0x3FFF / 0x0000 / 0xC000 stand for positive full scale, mid-scale and negative full scale.
- R3: A sample inside the selected range comes out unchanged as its low 16 bits, in two's complement, with `out_vld` high for exactly the one cycle after the cycle in which `in_vld` was high.
- R4: A clamped sample drives `clip` high in the same cycle its saturated word appears on `out_data`.
- R5: Once high, `clip` stays high through later samples in range, through writes to address 2 with bit 3 = 1, and through writes to any other address.
- R6: After reset, `clip` and `out_vld` are low and `out_data` is 0x0000.
- R7: A write (`ctl_wr` = 1) to address 2 with data bit 3 = 0 makes `clip` low in the next cycle, when no clamp happens in the write cycle.
- R8: When a clamped sample and a clearing write happen in the same cycle, `clip` stays high.
- R9: While `in_vld` is low, `out_data` keeps the last word and `out_vld` stays low, whatever `in_data` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample strobe for `in_data` |
| in_data | input | 18 | Signed wide receive sample |
| fmt_one_sign | input | 1 | 1: one sign bit, full 16-bit range; 0: two sign bits |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | 3 | Control register address |
| ctl_wdata | input | 12 | Control register write data |
| out_vld | output | 1 | Saturated word valid |
| out_data | output | 16 | Saturated output word |
| clip | output | 1 | Latched clip indicator |

## Verification
The bench builds the block with its default parameters: an 18-bit input, a 16-bit output and the clear control at address 2, bit 3. With an 18-bit input, a sweep in steps of 13 across the whole input range reaches every region for both formats: values far outside the range, the values just around each limit (those are covered one by one), and the values in range. Its own arithmetic model sets the expected word and flag for every sample. Directed sequences then show the flag staying set under the writes that must not clear it, the clear itself, the race between a clamp and a clear, and the output holding its word between samples.

// File: rtl/rx_sat_clip_pkg.sv
package rx_sat_clip_pkg;
  typedef enum logic {
    FMT_TWO_SIGN = 1'b0,
    FMT_ONE_SIGN = 1'b1
  } fmt_e;
endpackage

// File: rtl/rx_sat_clamp.sv
module rx_sat_clamp #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  input  logic             one_sign,
  output logic [OUT_W-1:0] dout,
  output logic             over
);
  import rx_sat_clip_pkg::*;

  localparam logic signed [IN_W-1:0] HI_FULL = IN_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [IN_W-1:0] LO_FULL = IN_W'(-(64'sd1 <<< (OUT_W-1)));
  localparam logic signed [IN_W-1:0] HI_HALF = IN_W'((64'sd1 <<< (OUT_W-2)) - 64'sd1);
  localparam logic signed [IN_W-1:0] LO_HALF = IN_W'(-(64'sd1 <<< (OUT_W-2)));

  logic signed [IN_W-1:0] sval;
  logic signed [IN_W-1:0] hi_lim;
  logic signed [IN_W-1:0] lo_lim;
  logic                   above;
  logic                   below;

  always_comb begin
    sval   = $signed(din);
    hi_lim = (fmt_e'(one_sign) == FMT_ONE_SIGN) ? HI_FULL : HI_HALF;
    lo_lim = (fmt_e'(one_sign) == FMT_ONE_SIGN) ? LO_FULL : LO_HALF;
    above  = sval > hi_lim;
    below  = sval < lo_lim;
    over   = above | below;
    if (above) begin
      dout = hi_lim[OUT_W-1:0];
    end else if (below) begin
      dout = lo_lim[OUT_W-1:0];
    end else begin
      dout = sval[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/rx_clip_latch.sv
module rx_clip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rx_sat_clip.sv
module rx_sat_clip #(
  parameter int IN_W     = 18,
  parameter int OUT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CTL_W    = 12,
  parameter int CLR_ADDR = 2,
  parameter int CLR_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IN_W-1:0]   in_data,
  input  logic              fmt_one_sign,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              out_vld,
  output logic [OUT_W-1:0]  out_data,
  output logic              clip
);
  localparam logic [ADDR_W-1:0] CLR_ADDR_V = ADDR_W'(CLR_ADDR);

  logic [OUT_W-1:0] sat_word;
  logic             sat_over;
  logic             clip_set;
  logic             clip_clr;
  logic             vld_q;
  logic             vld_d;
  logic [OUT_W-1:0] data_q;
  logic [OUT_W-1:0] data_d;
  logic             data_en;

  rx_sat_clamp #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
  ) clamp_i (
    .din      (in_data),
    .one_sign (fmt_one_sign),
    .dout     (sat_word),
    .over     (sat_over)
  );

  always_comb begin
    clip_set = in_vld & sat_over;
    clip_clr = ctl_wr & (ctl_addr == CLR_ADDR_V) & ~ctl_wdata[CLR_BIT];
  end

  rx_clip_latch clip_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (clip_set),
    .clr_i  (clip_clr),
    .flag_o (clip)
  );

  always_comb begin
    data_en = in_vld;
    vld_d   = in_vld;
    data_d  = data_en ? sat_word : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = data_q;
endmodule

// File: rtl/rx_sat_clip_chk.sv
module rx_sat_clip_chk #(
  parameter int IN_W     = 18,
  parameter int OUT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CTL_W    = 12,
  parameter int CLR_ADDR = 2,
  parameter int CLR_BIT  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [IN_W-1:0]   in_data,
  input logic              fmt_one_sign,
  input logic              ctl_wr,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic [CTL_W-1:0]  ctl_wdata,
  input logic              out_vld,
  input logic [OUT_W-1:0]  out_data,
  input logic              clip
);
  logic clr_wr;
  logic small_in;
  assign clr_wr   = ctl_wr && (ctl_addr == ADDR_W'(CLR_ADDR)) && !ctl_wdata[CLR_BIT];
  assign small_in = ($signed(in_data) <= $signed(IN_W'((1 << (OUT_W-2)) - 1))) &&
                    ($signed(in_data) >= $signed(IN_W'(-(1 << (OUT_W-2)))));

  // R4: the flag only rises after a sample was presented
  a_r4_rise_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clip) |-> $past(in_vld));

  // R5: without a clearing write the flag never drops
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clip && !clr_wr) |=> clip);

  // R7: clearing write with no sample empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !in_vld) |=> !clip);

  // R8: a sample that clamps keeps the flag set even under a clear
  a_r8_clamp_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !small_in && fmt_one_sign == 1'b0) |=> clip);

  // R2: two-sign output never leaves its range
  a_r2_two_sign_range: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !fmt_one_sign) |=> (out_data[OUT_W-1] == out_data[OUT_W-2]));

  // R3: small samples pass through unchanged, one cycle later
  a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && small_in) |=> (out_vld && out_data == $past(in_data[OUT_W-1:0])));

  // R9: no sample, no valid, word held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && $stable(out_data)));
endmodule

bind rx_sat_clip rx_sat_clip_chk #(
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .ADDR_W   (ADDR_W),
  .CTL_W    (CTL_W),
  .CLR_ADDR (CLR_ADDR),
  .CLR_BIT  (CLR_BIT)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_vld       (in_vld),
  .in_data      (in_data),
  .fmt_one_sign (fmt_one_sign),
  .ctl_wr       (ctl_wr),
  .ctl_addr     (ctl_addr),
  .ctl_wdata    (ctl_wdata),
  .out_vld      (out_vld),
  .out_data     (out_data),
  .clip         (clip)
);

// File: tb/rx_sat_clip_tb_top.sv
`timescale 1ns/1ps
module rx_sat_clip_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [17:0] in_data;
  logic        fmt_one_sign;
  logic        ctl_wr;
  logic [2:0]  ctl_addr;
  logic [11:0] ctl_wdata;
  logic        out_vld;
  logic [15:0] out_data;
  logic        clip;

  int n_chk;
  int n_bad;
  bit mclip;
  bit done;

  rx_sat_clip dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .in_data      (in_data),
    .fmt_one_sign (fmt_one_sign),
    .ctl_wr       (ctl_wr),
    .ctl_addr     (ctl_addr),
    .ctl_wdata    (ctl_wdata),
    .out_vld      (out_vld),
    .out_data     (out_data),
    .clip         (clip)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one sample, optionally with a write in the same cycle; checks the result
  task automatic sample(input int v, input bit fmt, input bit wr,
                        input int addr, input int wdata, input string req);
    int hi, lo, e;
    bit ov, clr;
    @(negedge clk);
    in_vld = 1'b1; in_data = v[17:0]; fmt_one_sign = fmt;
    ctl_wr = wr; ctl_addr = addr[2:0]; ctl_wdata = wdata[11:0];
    hi  = fmt ? 32767 : 16383;
    lo  = -hi - 1;
    e   = (v > hi) ? hi : ((v < lo) ? lo : v);
    ov  = (v > hi) || (v < lo);
    clr = wr && addr == 2 && wdata[3] == 1'b0;
    mclip = ov | (mclip & ~clr);
    @(negedge clk);
    in_vld = 1'b0; ctl_wr = 1'b0;
    check(out_vld == 1'b1, req, int'(out_vld), 1);
    check(out_data == e[15:0], req, int'(out_data), int'(e[15:0]));
    check(clip == mclip, {req, " clip"}, int'(clip), int'(mclip));
  endtask

  task automatic ctl_write(input int addr, input int wdata);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_addr = addr[2:0]; ctl_wdata = wdata[11:0];
    if (addr == 2 && wdata[3] == 1'b0) mclip = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; mclip = 1'b0; done = 1'b0;
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; fmt_one_sign = 1'b1;
    ctl_wr = 1'b0; ctl_addr = '0; ctl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check(clip == 1'b0, "R6", int'(clip), 0);
    check(out_vld == 1'b0, "R6", int'(out_vld), 0);
    check(out_data == 16'h0000, "R6", int'(out_data), 0);

    // R1/R2 full-scale and mid-scale code points
    sample(32767, 1'b1, 1'b0, 0, 0, "R1");
    sample(0, 1'b1, 1'b0, 0, 0, "R1");
    sample(-32768, 1'b1, 1'b0, 0, 0, "R1");
    check(clip == 1'b0, "R3 no clip in range", int'(clip), 0);
    sample(16383, 1'b0, 1'b0, 0, 0, "R2");
    sample(-16384, 1'b0, 1'b0, 0, 0, "R2");
    check(clip == 1'b0, "R3 no clip in range", int'(clip), 0);

    // R4 a clamp raises the flag with its word
    sample(16384, 1'b0, 1'b0, 0, 0, "R4");
    check(clip == 1'b1, "R4", int'(clip), 1);

    // R5 flag survives in-range samples and non-clearing writes
    sample(5, 1'b1, 1'b0, 0, 0, "R5");
    ctl_write(2, 12'h008);
    check(clip == 1'b1, "R5 bit3=1", int'(clip), 1);
    ctl_write(1, 12'h000);
    check(clip == 1'b1, "R5 other addr", int'(clip), 1);
    ctl_write(3, 12'h000);
    check(clip == 1'b1, "R5 other addr", int'(clip), 1);

    // R9 output held while idle
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_data = 18'(k * 40000 + 3);
      check(out_vld == 1'b0, "R9", int'(out_vld), 0);
      check(out_data == 16'h0005, "R9", int'(out_data), 5);
    end

    // R7 clear
    ctl_write(2, 12'hFF7);
    check(clip == 1'b0, "R7", int'(clip), 0);

    // R8 clamp and clear in the same cycle
    sample(-40000, 1'b1, 1'b1, 2, 0, "R8");
    check(clip == 1'b1, "R8", int'(clip), 1);
    // clear together with an in-range sample does clear
    sample(100, 1'b1, 1'b1, 2, 0, "R7 with sample");
    check(clip == 1'b0, "R7 with sample", int'(clip), 0);

    // limit neighbourhoods in both formats
    for (int f = 0; f < 2; f++) begin
      for (int d = -3; d <= 3; d++) begin
        sample(32767 + d, f[0], 1'b0, 0, 0, f[0] ? "R1" : "R2");
        sample(-32768 + d, f[0], 1'b0, 0, 0, f[0] ? "R1" : "R2");
        sample(16383 + d, f[0], 1'b0, 0, 0, f[0] ? "R3" : "R2");
        sample(-16384 + d, f[0], 1'b0, 0, 0, f[0] ? "R3" : "R2");
      end
    end
    ctl_write(2, 0);

    // coarse sweep of the whole input range, both formats
    for (int f = 0; f < 2; f++) begin
      for (int v = -131072; v < 131072; v += 13) begin
        sample(v, f[0], 1'b0, 0, 0, f[0] ? "R1 sweep" : "R2 sweep");
      end
      sample(131071, f[0], 1'b0, 0, 0, "R4 top");
      sample(-131072, f[0], 1'b0, 0, 0, "R4 bottom");
      ctl_write(2, 0);
      check(clip == 1'b0, "R7 after sweep", int'(clip), 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule